// File: doc/BRIEF.md
# Dual-Lane Registered Bidirectional Bus Transceiver

This block is the storage and enable core of a 16-bit bidirectional transceiver, split into two independent 8-bit lanes. Each lane carries data from an A side to a B side and from B back to A. Each direction has a hold register that can act in three ways. It can pass data straight through while its latch enable is high. It can keep the last value it saw once that enable drops. It can also take new data on a rising edge of a shared capture strobe while the enable is low. Data is never inverted.

A master disable and per-lane, per-direction output enables decide whether each side is driven. Each output is a plain data bus with a matching active-high drive-enable, so the pad ring can build the three-state buffers. All control inputs are sampled on the core clock `clk`. The capture strobe `cp` is treated as a level: a rising edge is a clock edge that sees it high after an edge that saw it low.

Top module: `xcvrCore`

## Requirements
- R1: While `leAb[n]` is 1, lane n of `bOut` equals lane n of `aIn` in the same cycle (lane n occupies bits n*8+7 down to n*8).
- R2: After `leAb[n]` falls, lane n of `bOut` keeps the `aIn` value sampled at the last clock edge where `leAb[n]` was 1, whether `cp` is steady high or steady low.
- R3: A `cp` rising edge (`cp` is 1 at a clock edge and was 0 at the previous edge) loads `aIn` into the lane's A-to-B register when `leAb[n]` is 0. After that edge, `bOut` shows the loaded value.
- R4: The B-to-A direction follows R1 to R3 with `leBa`, `bIn`, `aOut` and the same `cp`.
- R5: The controls of one lane never change the data or drive-enables of the other lane.
- R6: `bDrv[n]` is 1 exactly when `rstN` is 1, `allOff` is 0 and `oeAb[n]` is 1. `aDrv[n]` follows the same rule with `oeBa[n]`.
- R7: While `allOff` is 1, all bits of `aDrv` and `bDrv` are 0, whatever the per-lane enables are.
- R8: While `rstN` is 0, all held values are cleared to zero and all drive-enables are 0. Right after reset, a lane with its latch enable low outputs zero.
- R9: When a latch enable is 1 at the same edge as a `cp` rise, the output shows the live input, and the register holds that input after the enable drops.
- R10: Data is passed without inversion: the bit pattern 8'h5A on an input appears as 8'h5A on the opposite output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all controls are sampled on its rising edge |
| rstN | input | 1 | Active-low reset |
| cp | input | 1 | Shared capture strobe; acts on its rising edge |
| allOff | input | 1 | Master disable; 1 turns every drive-enable off |
| leAb | input | 2 | Per-lane A-to-B latch enable |
| leBa | input | 2 | Per-lane B-to-A latch enable |
| oeAb | input | 2 | Per-lane drive enable for the B side |
| oeBa | input | 2 | Per-lane drive enable for the A side |
| aIn | input | 16 | A-side input data |
| bIn | input | 16 | B-side input data |
| aOut | output | 16 | A-side output data |
| bOut | output | 16 | B-side output data |
| aDrv | output | 2 | Per-lane A-side drive-enable |
| bDrv | output | 2 | Per-lane B-side drive-enable |

## Verification
Transparency and clocked capture can fall in the same cycle. So can a latch enable falling and a capture edge. The bench sets up both on purpose. It raises `cp` while the enable is still high, and it drops the enable on the same edge where `cp` rises. It then checks that the output first follows the live input and then keeps exactly the value from the enable-high edge or the capture edge. A near-exhaustive sweep varies the controls of both lanes and both directions with arithmetic data patterns. The bench compares every output and drive-enable against a requirement-level model computed in the bench.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  parameter int LANES = 2;

  typedef struct packed {
    logic [LANES-1:0] loadAb;
    logic [LANES-1:0] loadBa;
    logic [LANES-1:0] passAb;
    logic [LANES-1:0] passBa;
    logic [LANES-1:0] drvAb;
    logic [LANES-1:0] drvBa;
  } xcvrStrobes_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cp,
  input  logic             allOff,
  input  logic [LANES-1:0] leAb,
  input  logic [LANES-1:0] leBa,
  input  logic [LANES-1:0] oeAb,
  input  logic [LANES-1:0] oeBa,
  output xcvrStrobes_t     strobes
);
  logic cpPrev;
  logic cpRise;
  logic outputsOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpPrev <= 1'b0;
    else       cpPrev <= cp;
  end

  assign cpRise    = cp & ~cpPrev;
  assign outputsOn = rstN & ~allOff;

  always_comb begin
    strobes.passAb = leAb;
    strobes.passBa = leBa;
    // a high enable keeps the register tracking; a strobe rise captures otherwise
    strobes.loadAb = leAb | {LANES{cpRise}};
    strobes.loadBa = leBa | {LANES{cpRise}};
    strobes.drvAb  = oeAb & {LANES{outputsOn}};
    strobes.drvBa  = oeBa & {LANES{outputsOn}};
  end
endmodule

// File: rtl/xcvrData.sv
module xcvrData
  import xcvrPkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobes_t     strobes,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  output logic [BUS_W-1:0] aOut,
  output logic [BUS_W-1:0] bOut
);
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_W-1:0] holdAb;
    logic [LANE_W-1:0] holdBa;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdAb <= '0;
        holdBa <= '0;
      end else begin
        if (strobes.loadAb[l]) holdAb <= aIn[l*LANE_W +: LANE_W];
        if (strobes.loadBa[l]) holdBa <= bIn[l*LANE_W +: LANE_W];
      end
    end

    assign bOut[l*LANE_W +: LANE_W] = strobes.passAb[l] ? aIn[l*LANE_W +: LANE_W] : holdAb;
    assign aOut[l*LANE_W +: LANE_W] = strobes.passBa[l] ? bIn[l*LANE_W +: LANE_W] : holdBa;
  end
endmodule

// File: rtl/xcvrCore.sv
module xcvrCore
  import xcvrPkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cp,
  input  logic             allOff,
  input  logic [LANES-1:0] leAb,
  input  logic [LANES-1:0] leBa,
  input  logic [LANES-1:0] oeAb,
  input  logic [LANES-1:0] oeBa,
  input  logic [BUS_W-1:0] aIn,
  input  logic [BUS_W-1:0] bIn,
  output logic [BUS_W-1:0] aOut,
  output logic [BUS_W-1:0] bOut,
  output logic [LANES-1:0] aDrv,
  output logic [LANES-1:0] bDrv
);
  xcvrStrobes_t strobes;

  xcvrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cp(cp), .allOff(allOff),
    .leAb(leAb), .leBa(leBa), .oeAb(oeAb), .oeBa(oeBa),
    .strobes(strobes)
  );

  xcvrData #(.LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut)
  );

  assign bDrv = strobes.drvAb;
  assign aDrv = strobes.drvBa;
endmodule

// File: rtl/xcvrCoreChecker.sv
module xcvrCoreChecker
  import xcvrPkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rstN,
  input logic             cp,
  input logic             allOff,
  input logic [LANES-1:0] leAb,
  input logic [LANES-1:0] leBa,
  input logic [BUS_W-1:0] aIn,
  input logic [BUS_W-1:0] bIn,
  input logic [BUS_W-1:0] aOut,
  input logic [BUS_W-1:0] bOut,
  input logic [LANES-1:0] aDrv,
  input logic [LANES-1:0] bDrv
);
  logic cpSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpSeen <= 1'b0;
    else       cpSeen <= cp;
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    leAb[0] |-> bOut[LANE_W-1:0] == aIn[LANE_W-1:0]); // R1

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb[0] && !(cp && !cpSeen)) |=> (leAb[0] || $stable(bOut[LANE_W-1:0]))); // R2

  AST_STROBE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (!leAb[0] && cp && !cpSeen) |=> (leAb[0] || bOut[LANE_W-1:0] == $past(aIn[LANE_W-1:0]))); // R3

  AST_REVERSE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    leBa[LANES-1] |-> aOut[BUS_W-1 -: LANE_W] == bIn[BUS_W-1 -: LANE_W]); // R4

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    allOff |-> (aDrv == '0 && bDrv == '0)); // R7

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (aDrv == '0 && bDrv == '0); // R8
  end
endmodule

bind xcvrCore xcvrCoreChecker #(.LANE_W(LANE_W)) chk (
  .clk(clk), .rstN(rstN), .cp(cp), .allOff(allOff),
  .leAb(leAb), .leBa(leBa), .aIn(aIn), .bIn(bIn),
  .aOut(aOut), .bOut(bOut), .aDrv(aDrv), .bDrv(bDrv)
);

// File: tb/xcvrCore_test.sv
module xcvrCore_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cp = 1'b0;
  logic allOff = 1'b0;
  logic [1:0] leAb = '0, leBa = '0, oeAb = '0, oeBa = '0;
  logic [15:0] aIn = '0, bIn = '0;
  logic [15:0] aOut, bOut;
  logic [1:0] aDrv, bDrv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] mAb [2];
  logic [W-1:0] mBa [2];
  logic mCp;

  xcvrCore uut (
    .clk(clk), .rstN(rstN), .cp(cp), .allOff(allOff),
    .leAb(leAb), .leBa(leBa), .oeAb(oeAb), .oeBa(oeBa),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut),
    .aDrv(aDrv), .bDrv(bDrv)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected outputs derived from the requirements and the bench's own model
  task automatic checkAll();
    for (int l = 0; l < 2; l++) begin
      logic [W-1:0] eb, ea;
      eb = leAb[l] ? aIn[l*W +: W] : mAb[l];
      ea = leBa[l] ? bIn[l*W +: W] : mBa[l];
      check(l == 0 ? (leAb[l] ? "R1 bOut" : "R3 bOut") : "R5 bOut lane1", bOut[l*W +: W], eb);
      check("R4 aOut", aOut[l*W +: W], ea);
    end
    check(allOff ? "R7 bDrv" : "R6 bDrv", bDrv, oeAb & {2{rstN & ~allOff}});
    check(allOff ? "R7 aDrv" : "R6 aDrv", aDrv, oeBa & {2{rstN & ~allOff}});
  endtask

  // advance one clock; the model follows what the requirements say about this edge
  task automatic tick();
    logic rise;
    @(posedge clk);
    rise = cp & ~mCp;
    if (rstN) begin
      for (int l = 0; l < 2; l++) begin
        if (leAb[l] || rise) mAb[l] = aIn[l*W +: W];
        if (leBa[l] || rise) mBa[l] = bIn[l*W +: W];
      end
      mCp = cp;
    end else begin
      mAb[0] = '0; mAb[1] = '0; mBa[0] = '0; mBa[1] = '0; mCp = 1'b0;
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mAb[0] = '0; mAb[1] = '0; mBa[0] = '0; mBa[1] = '0; mCp = 1'b0;
    // reset: enables requested but must stay off
    oeAb = 2'b11; oeBa = 2'b11; aIn = 16'hFFFF; bIn = 16'hFFFF;
    tick(); tick();
    check("R8 bDrv in reset", {14'd0, bDrv}, 16'd0);
    check("R8 aDrv in reset", {14'd0, aDrv}, 16'd0);
    rstN = 1'b1;
    #1;
    check("R8 bOut after reset", bOut, 16'h0000);
    check("R8 aOut after reset", aOut, 16'h0000);

    // R10: non-inverting pass-through
    leAb = 2'b01; aIn = 16'h005A; #1;
    check("R10 A to B pattern", {8'd0, bOut[7:0]}, 16'h005A);
    leBa = 2'b10; bIn = 16'h5A00; #1;
    check("R10 B to A pattern", {8'd0, aOut[15:8]}, 16'h005A);
    leBa = 2'b00;
    tick();

    // R2: enable falls while cp is held high, no capture must follow
    cp = 1'b1; aIn = 16'h0033; tick();
    leAb = 2'b00; aIn = 16'h00C4; tick(); tick();
    check("R2 hold with cp high", {8'd0, bOut[7:0]}, 16'h0033);
    cp = 1'b0; aIn = 16'h0071; tick();
    check("R2 hold with cp low", {8'd0, bOut[7:0]}, 16'h0071 & 16'h0000 | 16'h0033);

    // R3: strobe rise captures while enable low
    aIn = 16'h00E2; cp = 1'b1; tick();
    check("R3 capture on cp rise", {8'd0, bOut[7:0]}, 16'h00E2);

    // R9: enable high together with cp rise, then enable falls on the next edge
    cp = 1'b0; tick();
    leAb = 2'b01; cp = 1'b1; aIn = 16'h0019; #1;
    check("R9 live input wins", {8'd0, bOut[7:0]}, 16'h0019);
    tick();
    leAb = 2'b00; aIn = 16'h0088; tick();
    check("R9 value kept after enable drops", {8'd0, bOut[7:0]}, 16'h0019);
    // enable falls on the same edge as a strobe rise: strobe captures
    cp = 1'b0; leAb = 2'b01; aIn = 16'h0010; tick();
    leAb = 2'b00; cp = 1'b1; aIn = 16'h0020; tick();
    check("R3 capture on edge where enable dropped", {8'd0, bOut[7:0]}, 16'h0020);

    // R7: master disable overrides per-lane enables
    allOff = 1'b1; oeAb = 2'b11; oeBa = 2'b11; #1;
    check("R7 all drives off", {12'd0, aDrv, bDrv}, 16'd0);
    allOff = 1'b0; #1;
    check("R6 drives back on", {12'd0, aDrv, bDrv}, 16'h000F);

    // near-exhaustive sweep of controls with arithmetic data
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] c;
      c = 11'(i * 1103 + (i >> 4));
      leAb = c[1:0]; leBa = c[3:2]; oeAb = c[5:4]; oeBa = c[7:6];
      cp = c[8]; allOff = (c[10:9] == 2'b11);
      aIn = 16'(i * 40503 + 17);
      bIn = 16'(i * 12345 + 99);
      #1;
      checkAll();
      tick();
      checkAll();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule